// File: doc/BRIEF.md
# Two-Wire Identification Register Slave

This block answers on a two-wire serial bus at one fixed 7-bit address and hands out a fixed 64-bit identification value, one byte at a time. It also holds a single writable mode bit. The bus lines are oversampled by a fast system clock. The block never drives SDA high: it only requests a pull-down through an output-enable, so the pad can be wired as open drain.

A master first runs a write transaction. The first data byte after the address sets an internal byte pointer. A read transaction, either after a repeated START or in a later transaction, then streams bytes from that pointer, and the pointer advances by one after every byte. The mode bit is driven on a port so that a separate bus-timeout monitor can decide whether it is active. That monitor returns a reset strobe, which forces the bus engine back to idle and releases SDA.

Top module: `i2c_id_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1010000. Bit 0 of the address byte selects the direction, with 1 meaning read. For any other address it gives no acknowledge and ignores all clocks until the next START or STOP.
- R2: A START (SDA falls while SCL is high) is recognised in any state, including as a repeated START without a prior STOP. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R3: Bytes travel most significant bit first. On the ninth clock the block holds SDA low to acknowledge its own address and every data byte written to it.
- R4: Incoming bits are taken on the rising edge of SCL. An outgoing bit is changed only after a falling edge of SCL and stays unchanged while SCL is high.
- R5: The first data byte of a write transaction loads the pointer. Each further written byte goes to the pointed location. The 8-bit pointer increments by one after every written data byte and after every byte read, and it keeps its value across transactions.
- R6: A read at pointer k, for k from 0 to 7, returns bits 8k+7 to 8k of the ID_VALUE parameter. Pointer 8 returns the mode bit in bit 0 with bits 7 to 1 equal to 0. Any pointer above 8 returns FFh.
- R7: Only bit 0 of a byte written at pointer 8 changes state. Writes at pointers 0 to 7 or above 8 are acknowledged and have no effect.
- R8: The mode bit is 1 after reset and is presented on `ctrl_bit`.
- R9: When the master answers a read byte with a not-acknowledge (SDA high on the ninth clock), the block releases SDA and drives nothing until the next START or STOP.
- R10: A one-cycle `tmo_rst` pulse puts the bus engine into idle and releases SDA. The pointer and the mode bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| tmo_rst | input | 1 | Strobe from the timeout monitor that resets the bus engine |
| scl_in | input | 1 | Sensed level of the serial clock line |
| sda_in | input | 1 | Sensed level of the serial data line |
| sda_pull | output | 1 | When high, the pad pulls SDA low; otherwise SDA is released |
| ctrl_bit | output | 1 | Current value of the writable mode bit |

## Verification
The hardest situation to reach is a `tmo_rst` pulse that arrives while the block is actively pulling SDA low in the middle of a read. The bench gets there by pointing the pointer at the first ID byte, whose top bit is 0, and then issuing a read address. When the acknowledge clock falls, the block starts holding SDA low. The bench then fires the timeout strobe while SCL is parked low. It checks that SDA is free, and then checks that a fresh transaction still reads from the unchanged pointer. A not-acknowledge is followed by extra clocks, so that any leftover drive would show up on the wired line.

// File: rtl/i2c_id_pkg.sv
// Package: shared types for the two-wire identification slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_id_pkg;

    // Bus engine states.
    typedef enum logic [2:0] {
        ST_IDLE,     // no transaction for this slave
        ST_RX,       // shifting in an address or data byte
        ST_RX_END,   // eight bits in, waiting for SCL fall to decide
        ST_ACK_OUT,  // pulling SDA low for the ninth clock
        ST_TX,       // shifting a byte out
        ST_ACK_IN,   // waiting for the master's acknowledge bit
        ST_TX_LOAD,  // master acknowledged, next byte loads on SCL fall
        ST_WAIT      // not addressed or read ended, wait for START/STOP
    } bus_state_t;

endpackage

// File: rtl/i2c_id_linesync.sv
// Module: i2c_id_linesync
// Brings SCL and SDA into the clock domain through a synchronizer chain.
// It then flags the SCL edges and the START and STOP conditions, each as
// a single-cycle pulse.
// Assumes: the system clock is many times the bus bit rate; SYNC_STAGES >= 2.
module i2c_id_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_q;
    logic          sda_q;
    logic          scl_now;
    logic          sda_now;

    // Synchronizer chains; an idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_in};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_in};
        end
    end

    assign scl_now = scl_pipe[LAST];
    assign sda_now = sda_pipe[LAST];

    // One-cycle history of the synchronized lines, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_now;
            sda_q <= sda_now;
        end
    end

    assign sda_hi    = sda_now;
    assign scl_rise  = scl_now & ~scl_q;
    assign scl_fall  = ~scl_now & scl_q;
    assign start_det = scl_now & scl_q & sda_q & ~sda_now;
    assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/i2c_id_regs.sv
// Module: i2c_id_regs
// Holds the byte pointer and the single writable mode bit, and returns the
// byte at the pointer: an ID byte, the mode byte, or FFh.
// Assumes: ptr_load, wr_en and rd_adv are never asserted together;
// ID_BYTES is at most 255 and a power of two.
module i2c_id_regs #(
    parameter int                    ID_BYTES = 8,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE = 64'h8E01_2345_6789_AB70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_load,
    input  logic [7:0] ptr_data,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_adv,
    output logic [7:0] rd_data,
    output logic       ctrl_bit
);
    localparam int         IDX_W    = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam logic [7:0] CTRL_PTR = 8'(ID_BYTES);

    logic [7:0] ptr;
    logic       ctrl;
    logic [7:0] id_arr [ID_BYTES];

    // Split the ID parameter into byte lanes.
    for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
        assign id_arr[g] = ID_VALUE[8*g +: 8];
    end

    // Pointer: loaded by the first written byte, stepped after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= 8'd0;
        else if (ptr_load)         ptr <= ptr_data;
        else if (wr_en || rd_adv)  ptr <= ptr + 8'd1;
    end

    // Mode bit: only bit 0 of a write at the control location lands.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl <= 1'b1;
        else if (wr_en && ptr == CTRL_PTR)   ctrl <= wr_data[0];
    end

    // Read mux over ID bytes, the control byte and the empty range.
    always_comb begin
        if (ptr < CTRL_PTR)       rd_data = id_arr[ptr[IDX_W-1:0]];
        else if (ptr == CTRL_PTR) rd_data = {7'd0, ctrl};
        else                      rd_data = 8'hFF;
    end

    assign ctrl_bit = ctrl;

    // R5: a byte read moves the pointer by exactly one.
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> ptr == $past(ptr) + 8'd1);

    // R7: writes away from the control location leave the mode bit alone.
    a_r7_ro_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr != CTRL_PTR) |=> $stable(ctrl));

endmodule

// File: rtl/i2c_id_fsm.sv
// Module: i2c_id_fsm
// Bus engine: receives the address and write bytes, acknowledges them,
// shifts read bytes out, and issues strobes to the register file.
// Assumes: inputs are the single-cycle events from i2c_id_linesync.
module i2c_id_fsm
    import i2c_id_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmo_rst,
    input  logic       sda_hi,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_pull,
    output logic       ptr_load,
    output logic [7:0] ptr_data,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       rd_adv
);
    bus_state_t st;
    logic [2:0] cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       is_addr;
    logic       rd_mode;
    logic       ptr_set;
    logic       calm;

    // No overriding event this cycle.
    assign calm = !tmo_rst && !stop_det && !start_det;

    // State, bit counter and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n || tmo_rst) begin
            st      <= ST_IDLE;
            cnt     <= 3'd0;
            rx_sh   <= 8'd0;
            tx_sh   <= 8'hFF;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            ptr_set <= 1'b0;
        end else if (stop_det) begin
            st <= ST_IDLE;
        end else if (start_det) begin
            st      <= ST_RX;
            cnt     <= 3'd0;
            is_addr <= 1'b1;
            rd_mode <= 1'b0;
            ptr_set <= 1'b0;
        end else begin
            case (st)
                ST_RX: if (scl_rise) begin
                    rx_sh <= {rx_sh[6:0], sda_hi};
                    cnt   <= cnt + 3'd1;
                    if (cnt == 3'd7) st <= ST_RX_END;
                end
                ST_RX_END: if (scl_fall) begin
                    if (is_addr) begin
                        if (rx_sh[7:1] == DEV_ADDR) begin
                            rd_mode <= rx_sh[0];
                            st      <= ST_ACK_OUT;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end else begin
                        ptr_set <= 1'b1;
                        st      <= ST_ACK_OUT;
                    end
                end
                ST_ACK_OUT: if (scl_fall) begin
                    is_addr <= 1'b0;
                    cnt     <= 3'd0;
                    if (rd_mode) begin
                        tx_sh <= rd_data;
                        st    <= ST_TX;
                    end else begin
                        st <= ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'd7) begin
                        tx_sh <= 8'hFF;
                        st    <= ST_ACK_IN;
                    end else begin
                        tx_sh <= {tx_sh[6:0], 1'b1};
                    end
                end
                ST_ACK_IN: if (scl_rise) begin
                    st <= sda_hi ? ST_WAIT : ST_TX_LOAD;
                end
                ST_TX_LOAD: if (scl_fall) begin
                    tx_sh <= rd_data;
                    cnt   <= 3'd0;
                    st    <= ST_TX;
                end
                default: ;
            endcase
        end
    end

    // Register file strobes, decided on the SCL fall after a byte.
    always_comb begin
        ptr_load = calm && st == ST_RX_END && scl_fall && !is_addr && !ptr_set;
        wr_en    = calm && st == ST_RX_END && scl_fall && !is_addr && ptr_set;
        rd_adv   = calm && st == ST_TX && scl_fall && cnt == 3'd7;
    end

    assign ptr_data = rx_sh;
    assign wr_data  = rx_sh;

    // Open-drain request: acknowledge, or a zero data bit.
    assign sda_pull = (st == ST_ACK_OUT) || (st == ST_TX && !tx_sh[7]);

    // R2: a STOP always returns the engine to idle.
    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !tmo_rst) |=> (st == ST_IDLE && !sda_pull));

    // R4: a bit being sent holds its value until an SCL fall.
    a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && !scl_fall && calm) |=> sda_pull == $past(sda_pull));

    // R9: a not-acknowledge from the master ends all driving.
    a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK_IN && scl_rise && sda_hi && calm) |=> (st == ST_WAIT && !sda_pull));

    // R10: the timeout strobe idles the engine and frees SDA.
    a_r10_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_rst |=> (st == ST_IDLE && !sda_pull));

endmodule

// File: rtl/i2c_id_slave.sv
// Module: i2c_id_slave (top)
// Two-wire slave at a fixed address that reads out a fixed ID value and
// holds one writable mode bit. It wires together the line synchronizer,
// the bus engine and the register file.
// Assumes: the SDA pad pulls low when sda_pull is high and is released
// otherwise; scl_in and sda_in carry the pad levels.
module i2c_id_slave #(
    parameter logic [6:0]            DEV_ADDR    = 7'b1010000,
    parameter int                    ID_BYTES    = 8,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE    = 64'h8E01_2345_6789_AB70,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull,
    output logic ctrl_bit
);
    logic       sda_hi;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       ptr_load;
    logic [7:0] ptr_data;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_adv;
    logic [7:0] rd_data;

    i2c_id_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_hi    (sda_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_id_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_rst   (tmo_rst),
        .sda_hi    (sda_hi),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull),
        .ptr_load  (ptr_load),
        .ptr_data  (ptr_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_adv    (rd_adv)
    );

    i2c_id_regs #(.ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_load (ptr_load),
        .ptr_data (ptr_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_adv   (rd_adv),
        .rd_data  (rd_data),
        .ctrl_bit (ctrl_bit)
    );

endmodule

// File: tb/i2c_id_slave_bench.sv
// Bench for i2c_id_slave. A behavioural bus master drives SCL and SDA,
// resolves the wired-AND line, and compares every sampled bit with a
// reference model of the pointer and the mode bit.
module i2c_id_slave_bench;
    localparam logic [63:0] ID = 64'h8E01_2345_6789_AB70;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmo_rst = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic ctrl_bit;
    logic sda_line;

    int n_chk = 0;
    int n_err = 0;
    int m_ptr = 0;
    logic m_ctrl = 1'b1;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = sda_m & ~sda_pull;

    i2c_id_slave u_i2c_id_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_rst  (tmo_rst),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .ctrl_bit (ctrl_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    // Model of the byte returned at a pointer (R6).
    function automatic logic [7:0] model_rd(input int p);
        if (p < 8)       return ID[8*p +: 8];
        else if (p == 8) return {7'd0, m_ctrl};
        else             return 8'hFF;
    endfunction

    task automatic bit_clk(input logic b, output logic got);
        sda_m = b; qw();
        scl_m = 1'b1; qw();
        got = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic g;
        for (int i = 7; i >= 0; i--) bit_clk(b[i], g);
        bit_clk(1'b1, g);
        chk(req, int'(g), exp_ack ? 0 : 1);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
        logic g;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, g);
            v[i] = g;
        end
        chk(req, int'(v), int'(exp));
        bit_clk(mack ? 1'b0 : 1'b1, g);
    endtask

    // Model-driven register write transaction: pointer then data bytes.
    task automatic set_ptr(input int p);
        bus_start();
        send_byte(8'hA0, 1'b1, "R1 address write ack");
        send_byte(8'(p), 1'b1, "R3 pointer byte ack");
        m_ptr = p;
    endtask

    task automatic wr_data_byte(input logic [7:0] d, input string req);
        send_byte(d, 1'b1, req);
        if (m_ptr == 8) m_ctrl = d[0];
        m_ptr = (m_ptr + 1) % 256;
    endtask

    task automatic rd_bytes(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            recv_byte(model_rd(m_ptr), k != n - 1, req);
            m_ptr = (m_ptr + 1) % 256;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic g;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 mode bit after reset", int'(ctrl_bit), 1);
        chk("R2 idle release after reset", int'(sda_pull), 0);

        // R1: foreign address is not acknowledged, following byte ignored.
        bus_start();
        send_byte(8'hA4, 1'b0, "R1 foreign address nack");
        send_byte(8'h00, 1'b0, "R1 ignored after foreign address");
        bus_stop();

        // R5/R6: set pointer 0, repeated START, read the whole map and beyond.
        set_ptr(0);
        bus_start();
        send_byte(8'hA1, 1'b1, "R2 repeated start read ack");
        rd_bytes(10, "R6 sequential read");
        // R9: after NACK, extra clocks see only the master's high level.
        for (int i = 0; i < 9; i++) begin
            bit_clk(1'b1, g);
            chk("R9 released after nack", int'(g), 1);
        end
        bus_stop();
        chk("R2 stop releases line", int'(sda_pull), 0);

        // R7/R5: write through ID 07 (ignored) into the mode byte.
        set_ptr(7);
        wr_data_byte(8'hAA, "R7 read-only write acked");
        wr_data_byte(8'h00, "R7 mode write acked");
        bus_stop();
        repeat (5) @(negedge clk);
        chk("R7 mode bit cleared", int'(ctrl_bit), int'(m_ctrl));

        // R5: pointer persists across transactions (now past the map).
        bus_start();
        send_byte(8'hA1, 1'b1, "R1 address read ack");
        rd_bytes(1, "R5 pointer persists past map");
        bus_stop();

        // R6/R7: only bit 0 of the mode byte changes; upper bits read 0.
        set_ptr(8);
        wr_data_byte(8'hFF, "R7 mode write all ones");
        bus_start();
        send_byte(8'hA0, 1'b1, "R1 address write ack");
        send_byte(8'h08, 1'b1, "R3 pointer byte ack");
        m_ptr = 8;
        bus_start();
        send_byte(8'hA1, 1'b1, "R2 repeated start read ack");
        rd_bytes(2, "R6 mode byte and empty range");
        bus_stop();
        chk("R8 mode bit port", int'(ctrl_bit), 1);
        set_ptr(8);
        wr_data_byte(8'hFE, "R7 mode write even value");
        bus_stop();
        repeat (5) @(negedge clk);
        chk("R7 bit 0 decides mode", int'(ctrl_bit), 0);

        // R7: write to ID byte 3 has no effect on its read value.
        set_ptr(3);
        wr_data_byte(8'h55, "R7 id write acked");
        bus_start();
        send_byte(8'hA0, 1'b1, "R1 address write ack");
        send_byte(8'h03, 1'b1, "R3 pointer byte ack");
        m_ptr = 3;
        bus_start();
        send_byte(8'hA1, 1'b1, "R2 repeated start read ack");
        rd_bytes(3, "R7 id bytes unchanged");
        bus_stop();

        // R10: timeout while the slave pulls SDA low for a zero data bit.
        set_ptr(0);
        bus_start();
        send_byte(8'hA1, 1'b1, "R1 address read ack");
        chk("R4 first data bit driven after fall", int'(sda_pull), 1);
        @(negedge clk) tmo_rst = 1'b1;
        @(negedge clk) tmo_rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 timeout releases line", int'(sda_pull), 0);
        chk("R10 mode bit kept", int'(ctrl_bit), int'(m_ctrl));
        bus_stop();
        bus_start();
        send_byte(8'hA1, 1'b1, "R10 new transaction after timeout");
        rd_bytes(2, "R10 pointer kept across timeout");
        bus_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule